// File: doc/BRIEF.md
# Pretrigger Circular Capture Controller

This controller runs a sampled acquisition into a ring of `DEPTH` entries. Each accepted sample strobe writes three values at one ring index: two analog channel codes and a 16-bit digital input word. The write index advances with every sample and wraps at the end of the ring, so the oldest data is always overwritten first. The controller drives a plain write port and leaves the storage itself to a memory outside it.

A trigger pulse is honoured only after at least half the ring holds history, or after the ring has wrapped once. The first trigger that qualifies captures the write index. The controller then stores exactly `DEPTH/2` further samples and stops, which places the trigger close to the middle of the record. An abort input ends the acquisition at any time, for example when an outside timeout expires. It leaves the triggered flag as it stood. The controller also reports how many clock cycles each complete pass around the ring took. After completion the final write index is held. Readout starts there (the oldest entry), runs to `DEPTH-1`, and then continues from 0 up to one below that index.

Top module: `pretrig_capture`

## Requirements
- R1: When a sample is accepted during acquisition, `wr_en_o` is high for one cycle in the next cycle. In that cycle `wr_addr_o` equals the write index from the accepting cycle, and `wr_ch1_o`, `wr_ch2_o` and `wr_dig_o` carry the inputs from the accepting cycle.
- R2: The write index `wr_idx_o` is 0 after start. It rises by one per accepted sample and goes from `DEPTH-1` back to 0.
- R3: `pass_cycles_o` is cleared by start. On every wrap it takes the count of acquisition clock cycles since the start (or since the previous wrap), including the wrapping cycle.
- R4: A trigger is ignored while the write index is below `DEPTH/2` and the ring has not yet wrapped. It is eligible at an index of exactly `DEPTH/2`, and at any index once a wrap has occurred.
- R5: The first eligible trigger sets `triggered_o` and latches the write index from its own cycle (before any increment from a sample in that cycle) into `trig_idx_o`. All later triggers are ignored until the next start.
- R6: A sample accepted in a cycle after the trigger cycle counts as post-trigger. On the `DEPTH/2`-th counted sample the acquisition ends and `done_o` rises in the following cycle.
- R7: An abort during acquisition ends it. `done_o` rises in the next cycle, and any sample or trigger in the abort cycle is discarded. `triggered_o` keeps its value, so it stays low if no trigger occurred.
- R8: Outside acquisition, samples, triggers and aborts have no effect. `done_o`, `wr_idx_o`, `trig_idx_o`, `triggered_o` and `pass_cycles_o` hold until the next start.
- R9: Start has priority over every other input and restarts from any state. In the next cycle the index, the pass count and both flags are 0.
- R10: After reset all outputs are 0 and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new acquisition |
| sample_i | input | 1 | Sample strobe |
| ch1_i | input | CH_W | Channel 1 code |
| ch2_i | input | CH_W | Channel 2 code |
| dig_i | input | DIG_W | Digital input word |
| trig_i | input | 1 | Trigger pulse |
| abort_i | input | 1 | Stop or timeout request |
| wr_en_o | output | 1 | Ring write enable |
| wr_addr_o | output | IDX_W | Ring write address |
| wr_ch1_o | output | CH_W | Channel 1 write data |
| wr_ch2_o | output | CH_W | Channel 2 write data |
| wr_dig_o | output | DIG_W | Digital write data |
| wr_idx_o | output | IDX_W | Next write index; oldest entry once done |
| trig_idx_o | output | IDX_W | Latched index at the trigger |
| triggered_o | output | 1 | A trigger was accepted |
| done_o | output | 1 | Acquisition finished |
| pass_cycles_o | output | TIME_W | Cycles taken by the last full ring pass |

## Verification
The bench probes the edges of the trigger window: one trigger one index below half, one trigger at exactly half, and one trigger after a wrap at a low index. A window test that is off by one would latch the wrong index or never trigger. It pairs a trigger with a sample in the same cycle and pairs a sample with an abort. A design that counted the trigger's own sample, or let an abort store data, would end at the wrong final index or write once too often. It restarts in the middle of a run that has already triggered, and pokes the idle controller after completion. Stale flags, a moving index or stray writes then show up against the cycle model.

// File: rtl/pretrig_capture_pkg.sv
package pretrig_capture_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_RUN  = 2'd1,
    CAP_DONE = 2'd2
  } cap_state_e;

  // next ring position, wrapping at depth
  function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  // trigger acceptance window: half the ring written or ring wrapped once
  function automatic bit window_open(bit wrapped, int unsigned idx, int unsigned depth);
    return wrapped || (idx >= depth / 2);
  endfunction

  // true when one more counted sample completes the post-trigger half
  function automatic bit post_full(int unsigned cnt, int unsigned depth);
    return (cnt + 1) == (depth / 2);
  endfunction

endpackage

// File: rtl/cap_index_ctr.sv
module cap_index_ctr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic             filled,
  output logic             wrap_ev
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;
  logic             filled_q;

  assign wrap_ev = advance && (idx_q == LAST_IDX);
  assign idx     = idx_q;
  assign filled  = filled_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      filled_q <= 1'b0;
    end else if (clear) begin
      idx_q    <= '0;
      filled_q <= 1'b0;
    end else if (advance) begin
      idx_q <= IDX_W'(pretrig_capture_pkg::ring_next(32'(idx_q), DEPTH));
      if (wrap_ev) filled_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cap_trig_gate.sv
module cap_trig_gate #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             arm,
  input  logic             trig_in,
  input  logic [IDX_W-1:0] idx,
  input  logic             filled,
  output logic             trig_acc,
  output logic             triggered,
  output logic [IDX_W-1:0] trig_idx
);
  logic             trig_q;
  logic [IDX_W-1:0] tidx_q;
  logic             open_w;

  assign open_w    = pretrig_capture_pkg::window_open(filled, 32'(idx), DEPTH);
  assign trig_acc  = arm && trig_in && !trig_q && open_w;
  assign triggered = trig_q;
  assign trig_idx  = tidx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      tidx_q <= '0;
    end else if (clear) begin
      trig_q <= 1'b0;
      tidx_q <= '0;
    end else if (trig_acc) begin
      trig_q <= 1'b1;
      tidx_q <= idx;
    end
  end
endmodule

// File: rtl/cap_post_ctr.sv
module cap_post_ctr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned HALF = DEPTH / 2,
  localparam int unsigned CW   = $clog2(HALF + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  output logic post_last
);
  logic [CW-1:0] cnt_q;

  assign post_last = count_en && pretrig_capture_pkg::post_full(32'(cnt_q), DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (count_en) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cap_pass_timer.sv
module cap_pass_timer #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic              wrap,
  output logic [TIME_W-1:0] pass_cycles
);
  logic [TIME_W-1:0] tick_q;
  logic [TIME_W-1:0] pass_q;
  logic [TIME_W-1:0] tick_inc;

  assign tick_inc    = tick_q + 1'b1;
  assign pass_cycles = pass_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      tick_q <= '0;
      pass_q <= '0;
    end else if (run) begin
      if (wrap) begin
        pass_q <= tick_inc;
        tick_q <= '0;
      end else begin
        tick_q <= tick_inc;
      end
    end
  end
endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CH_W   = 12,
  parameter int unsigned DIG_W  = 16,
  parameter int unsigned TIME_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sample_i,
  input  logic [CH_W-1:0]   ch1_i,
  input  logic [CH_W-1:0]   ch2_i,
  input  logic [DIG_W-1:0]  dig_i,
  input  logic              trig_i,
  input  logic              abort_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_addr_o,
  output logic [CH_W-1:0]   wr_ch1_o,
  output logic [CH_W-1:0]   wr_ch2_o,
  output logic [DIG_W-1:0]  wr_dig_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [IDX_W-1:0]  trig_idx_o,
  output logic              triggered_o,
  output logic              done_o,
  output logic [TIME_W-1:0] pass_cycles_o
);
  import pretrig_capture_pkg::*;

  cap_state_e state_q;

  // named internal events
  logic running;
  logic live;
  logic sample_acc;
  logic abort_acc;
  logic trig_acc;
  logic wrap_ev;
  logic post_last;
  logic filled;
  logic [IDX_W-1:0] idx;

  assign running    = (state_q == CAP_RUN);
  assign live       = running && !abort_i && !start_i;
  assign sample_acc = live && sample_i;
  assign abort_acc  = running && abort_i && !start_i;

  cap_index_ctr #(.DEPTH(DEPTH)) u_index (
    .clk(clk), .rst_n(rst_n), .clear(start_i), .advance(sample_acc),
    .idx(idx), .filled(filled), .wrap_ev(wrap_ev)
  );

  cap_trig_gate #(.DEPTH(DEPTH)) u_trig (
    .clk(clk), .rst_n(rst_n), .clear(start_i), .arm(live), .trig_in(trig_i),
    .idx(idx), .filled(filled), .trig_acc(trig_acc),
    .triggered(triggered_o), .trig_idx(trig_idx_o)
  );

  cap_post_ctr #(.DEPTH(DEPTH)) u_post (
    .clk(clk), .rst_n(rst_n), .clear(start_i),
    .count_en(sample_acc && triggered_o), .post_last(post_last)
  );

  cap_pass_timer #(.TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(start_i), .run(running),
    .wrap(wrap_ev), .pass_cycles(pass_cycles_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
    end else if (start_i) begin
      state_q <= CAP_RUN;
    end else if (abort_acc || post_last) begin
      state_q <= CAP_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_ch1_o  <= '0;
      wr_ch2_o  <= '0;
      wr_dig_o  <= '0;
    end else begin
      wr_en_o <= sample_acc;
      if (sample_acc) begin
        wr_addr_o <= idx;
        wr_ch1_o  <= ch1_i;
        wr_ch2_o  <= ch2_i;
        wr_dig_o  <= dig_i;
      end
    end
  end

  assign wr_idx_o = idx;
  assign done_o   = (state_q == CAP_DONE);

endmodule

// File: rtl/pretrig_capture_chk.sv
module pretrig_capture_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             sample_acc,
  input logic             abort_acc,
  input logic             trig_acc,
  input logic             wrap_ev,
  input logic             post_last,
  input logic             filled,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] wr_addr_o,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic [IDX_W-1:0] trig_idx_o,
  input logic             triggered_o,
  input logic             done_o
);
  localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(DEPTH / 2);

  // R1
  write_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_acc |=> (wr_en_o && wr_addr_o == $past(wr_idx_o)));

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (wr_idx_o == '0));

  // R4
  trig_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_acc |-> (filled || wr_idx_o >= HALF_IDX));

  // R5
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered_o && !start_i) |=> (triggered_o && $stable(trig_idx_o)));

  // R6
  post_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_last |=> done_o);

  // R7
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_acc |=> (done_o && !wr_en_o && triggered_o == $past(triggered_o)));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && !wr_en_o && $stable(wr_idx_o)));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !triggered_o && wr_idx_o == '0));

endmodule

bind pretrig_capture pretrig_capture_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_acc(sample_acc),
  .abort_acc(abort_acc), .trig_acc(trig_acc), .wrap_ev(wrap_ev),
  .post_last(post_last), .filled(filled), .wr_en_o(wr_en_o),
  .wr_addr_o(wr_addr_o), .wr_idx_o(wr_idx_o), .trig_idx_o(trig_idx_o),
  .triggered_o(triggered_o), .done_o(done_o)
);

// File: tb/pretrig_capture_bench.sv
module pretrig_capture_bench;
  localparam int DEPTH  = 16;
  localparam int HALF   = DEPTH / 2;
  localparam int CH_W   = 12;
  localparam int DIG_W  = 16;
  localparam int TIME_W = 32;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, sample_i = 1'b0, trig_i = 1'b0, abort_i = 1'b0;
  logic [CH_W-1:0]  ch1_i = '0, ch2_i = '0;
  logic [DIG_W-1:0] dig_i = '0;
  logic wr_en_o, triggered_o, done_o;
  logic [IDX_W-1:0] wr_addr_o, wr_idx_o, trig_idx_o;
  logic [CH_W-1:0]  wr_ch1_o, wr_ch2_o;
  logic [DIG_W-1:0] wr_dig_o;
  logic [TIME_W-1:0] pass_cycles_o;

  always #4 clk = ~clk;

  pretrig_capture #(.DEPTH(DEPTH), .CH_W(CH_W), .DIG_W(DIG_W), .TIME_W(TIME_W))
  u_pretrig_capture (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_i(sample_i),
    .ch1_i(ch1_i), .ch2_i(ch2_i), .dig_i(dig_i), .trig_i(trig_i), .abort_i(abort_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_ch1_o(wr_ch1_o),
    .wr_ch2_o(wr_ch2_o), .wr_dig_o(wr_dig_o), .wr_idx_o(wr_idx_o),
    .trig_idx_o(trig_idx_o), .triggered_o(triggered_o), .done_o(done_o),
    .pass_cycles_o(pass_cycles_o)
  );

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  bit m_run, m_done, m_filled, m_trig, m_wen;
  int m_idx, m_tidx, m_post, m_timer, m_pass, m_waddr;
  int m_c1, m_c2, m_dg;
  string tag_trig = "R5";
  string tag_done = "R6";

  task automatic chk(string tag, longint got, longint exp, string what);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_filled = 0; m_trig = 0; m_wen = 0;
      m_idx = 0; m_tidx = 0; m_post = 0; m_timer = 0; m_pass = 0;
      m_waddr = 0; m_c1 = 0; m_c2 = 0; m_dg = 0;
      return;
    end
    m_wen = 0;
    if (start_i) begin
      m_run = 1; m_done = 0; m_filled = 0; m_trig = 0; m_tidx = 0;
      m_idx = 0; m_post = 0; m_timer = 0; m_pass = 0;
    end else if (m_run) begin
      int tn;
      bit counted;
      tn = m_timer + 1;
      if (abort_i) begin
        m_run = 0; m_done = 1; m_timer = tn;
      end else begin
        counted = m_trig;
        if (trig_i && !m_trig && (m_filled || m_idx >= HALF)) begin
          m_trig = 1; m_tidx = m_idx;
        end
        if (sample_i) begin
          m_wen = 1; m_waddr = m_idx;
          m_c1 = int'(ch1_i); m_c2 = int'(ch2_i); m_dg = int'(dig_i);
          if (m_idx == DEPTH - 1) begin
            m_idx = 0; m_filled = 1; m_pass = tn; m_timer = 0;
          end else begin
            m_idx++; m_timer = tn;
          end
          if (counted) begin
            m_post++;
            if (m_post == HALF) begin m_run = 0; m_done = 1; end
          end
        end else begin
          m_timer = tn;
        end
      end
    end
  endtask

  task automatic compare_all();
    chk("R1", wr_en_o, m_wen, "wr_en");
    if (m_wen) begin
      chk("R1", wr_addr_o, m_waddr, "wr_addr");
      chk("R1", wr_ch1_o, m_c1, "wr_ch1");
      chk("R1", wr_ch2_o, m_c2, "wr_ch2");
      chk("R1", wr_dig_o, m_dg, "wr_dig");
    end
    chk("R2", wr_idx_o, m_idx, "wr_idx");
    chk("R3", pass_cycles_o, m_pass, "pass_cycles");
    chk(tag_trig, triggered_o, m_trig, "triggered");
    chk(tag_trig, trig_idx_o, m_tidx, "trig_idx");
    chk(tag_done, done_o, m_done, "done");
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(bit s, bit t, bit a, bit st);
    sample_i = s; trig_i = t; abort_i = a; start_i = st;
    ch1_i = CH_W'($urandom); ch2_i = CH_W'($urandom); dig_i = DIG_W'($urandom);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog expired: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc(0, 0, 0, 0);
    // R10: reset state
    chk("R10", done_o, 0, "done after reset");
    chk("R10", wr_en_o, 0, "wr_en after reset");
    chk("R10", wr_idx_o, 0, "idx after reset");
    rst_n = 1'b1;
    tag_done = "R10";
    cyc(1, 1, 0, 0); cyc(1, 0, 1, 0);
    chk("R10", triggered_o, 0, "idle trigger ignored");

    // run 1: every cycle sampled, window edges
    tag_done = "R6";
    cyc(0, 0, 0, 1);
    chk("R9", wr_idx_o, 0, "index after start");
    tag_trig = "R4";
    for (int k = 0; k < HALF; k++) cyc(1, (k == 3 || k == HALF - 1), 0, 0);
    chk("R4", triggered_o, 0, "trigger below half ignored");
    tag_trig = "R5";
    cyc(1, 1, 0, 0);
    chk("R5", trig_idx_o, HALF, "trigger at half latched");
    cyc(1, 1, 0, 0);
    chk("R5", trig_idx_o, HALF, "second trigger ignored");
    for (int k = 0; k < HALF + 4; k++) cyc(1, 0, 0, 0);
    chk("R3", pass_cycles_o, DEPTH, "pass for full-rate ring");
    chk("R6", done_o, 1, "done after half ring");
    chk("R6", wr_idx_o, (HALF + 1 + HALF) % DEPTH, "final index");
    tag_done = "R8";
    for (int k = 0; k < 4; k++) cyc(1, 1, k == 2, 0);
    chk("R8", wr_idx_o, (HALF + 1 + HALF) % DEPTH, "idx held when done");

    // run 2: every third cycle, trigger only after wrap at low index
    tag_done = "R6";
    cyc(0, 0, 0, 1);
    for (int k = 0; k < DEPTH * 3; k++) cyc((k % 3) == 2, 0, 0, 0);
    chk("R3", pass_cycles_o, DEPTH * 3, "pass for slow ring");
    cyc(0, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    tag_trig = "R4";
    cyc(0, 1, 0, 0);
    chk("R4", trig_idx_o, 2, "trigger after wrap at low index");
    tag_trig = "R5";
    for (int k = 0; k < DEPTH * 2; k++) cyc((k % 2) == 0, 0, 0, 0);
    chk("R6", done_o, 1, "done after slow post run");

    // run 3: abort without trigger, sample and trigger in abort cycle
    tag_done = "R7";
    tag_trig = "R7";
    cyc(0, 0, 0, 1);
    for (int k = 0; k < HALF + 2; k++) cyc(1, 0, 0, 0);
    cyc(1, 1, 1, 0);
    chk("R7", triggered_o, 0, "abort leaves untriggered");
    chk("R7", wr_en_o, 0, "abort sample discarded");
    chk("R7", done_o, 1, "abort ends capture");

    // run 4: restart mid-run after trigger, then abort while triggered
    tag_done = "R9";
    tag_trig = "R9";
    cyc(0, 0, 0, 1);
    for (int k = 0; k < HALF + 1; k++) cyc(1, k == HALF, 0, 0);
    cyc(1, 1, 1, 1);
    chk("R9", triggered_o, 0, "start clears trigger");
    chk("R9", pass_cycles_o, 0, "start clears pass");
    tag_trig = "R7";
    tag_done = "R7";
    for (int k = 0; k < HALF; k++) cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    cyc(1, 0, 1, 0);
    chk("R7", triggered_o, 1, "abort keeps trigger");
    chk("R7", trig_idx_o, HALF, "abort keeps trigger index");
    repeat (3) cyc(1, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule